// File: doc/BRIEF.md
# Nibble ALU with Registered Condition Flags

This block is the arithmetic and logic datapath of a small 4-bit processor core. Each cycle it takes two register operands (A and B), an operand fetched from data memory, and a 3-bit operation select. It produces a combinational result and a destination code that tells the surrounding core which register, if any, should capture that result. The zero, sign and carry condition flags live inside the block. They are updated on the clock edge when the operation enable is high and the selected operation affects flags.

The operations are add, subtract, bitwise AND, OR with memory, XOR with memory, a flag-only test (AND of B with memory, with no write-back), and rotate-right of B through the carry flag. A no-operation code passes A through, names no destination and leaves the flags alone. Register storage, instruction fetch and decode belong to the surrounding core.

Reset is asynchronous and active low. Its release is synchronised to the clock through two flops, and the flags stay cleared until the release has passed through them.

Top module: `nib_alu`

## Requirements
- R1: While reset is asserted, and after it is released, all three flags read 0 until an operation changes them.
- R2: op_sel 1 (add) gives result = (A+B) mod 16 with dest 1 (A). On the edge the zero flag is set exactly when the result is 0, carry takes the carry-out of the 5-bit sum, and sign keeps its value.
- R3: op_sel 2 (subtract) gives result = (A−B) mod 16 with dest 1 (A). On the edge zero reflects a zero result, and both sign and carry are set exactly when A < B unsigned.
- R4: op_sel 3 (AND) gives result = A&B with dest 1 (A). On the edge zero reflects the result, carry is cleared and sign is kept.
- R5: op_sel 4 gives B|M with dest 2 (B), and op_sel 5 gives A^M with dest 1 (A). The flags follow the same rule as R4.
- R6: op_sel 6 (test) gives result = B&M with dest 0 (no write). Zero reflects that value, carry is cleared and sign is kept.
- R7: op_sel 7 (rotate) gives result = {carry flag, B[3:1]} with dest 2 (B). On the edge carry takes B[0], and zero and sign are kept.
- R8: op_sel 0 (no-op) gives result = A and dest 0, and leaves all three flags unchanged.
- R9: With op_en low, the flags keep their values for any op_sel and operands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_en | input | 1 | Flag update enable for this cycle |
| op_sel | input | 3 | Operation select (0 nop,1 add,2 sub,3 and,4 or,5 xor,6 test,7 rotate) |
| opa | input | W | Register A operand |
| opb | input | W | Register B operand |
| opm | input | W | Data memory operand |
| result | output | W | Combinational operation result |
| dest | output | 2 | Write-back target: 0 none, 1 A, 2 B |
| flag_z | output | 1 | Zero flag (registered) |
| flag_s | output | 1 | Sign flag (registered) |
| flag_c | output | 1 | Carry flag (registered) |

## Verification
The bench builds the block with its default W of 4. At that width every A,B pair for add and subtract, and every operand pair for the logic operations, is a sweep of only 256 steps. Carry-out at 15+1, borrow at 0−1 and the zero results are therefore all covered exhaustively rather than sampled. Rotate chains feed each carry-out back into the next most significant bit, and the no-op, disabled-update and mid-run reset cases are placed directly after operations that left non-zero flags.

// File: rtl/nib_alu_pkg.sv
package nib_alu_pkg;
  typedef enum logic [2:0] {
    OP_NOP  = 3'd0,
    OP_ADD  = 3'd1,
    OP_SUB  = 3'd2,
    OP_AND  = 3'd3,
    OP_OR   = 3'd4,
    OP_XOR  = 3'd5,
    OP_TEST = 3'd6,
    OP_RCR  = 3'd7
  } alu_op_e;

  typedef enum logic [1:0] {
    DST_NONE = 2'd0,
    DST_A    = 2'd1,
    DST_B    = 2'd2
  } dst_e;

  typedef struct packed {
    logic z;
    logic s;
    logic c;
  } flags_t;

  localparam int LOGIC_SEL_W = 2;
endpackage

// File: rtl/nib_alu_arith.sv
module nib_alu_arith #(
  parameter int W = 4
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         sub,
  output logic [W-1:0] res,
  output logic         cout
);
  localparam int EXT_W = W + 1;

  logic [EXT_W-1:0] ext;

  always_comb begin
    if (sub) ext = {1'b0, a} - {1'b0, b};
    else     ext = {1'b0, a} + {1'b0, b};
  end

  assign res  = ext[W-1:0];
  assign cout = ext[W];
endmodule

// File: rtl/nib_alu_logic.sv
module nib_alu_logic
  import nib_alu_pkg::*;
#(
  parameter int W = 4
) (
  input  logic [W-1:0]           a,
  input  logic [W-1:0]           b,
  input  logic [W-1:0]           m,
  input  logic [LOGIC_SEL_W-1:0] sel,
  output logic [W-1:0]           res
);
  // sel: 0 A&B, 1 B|M, 2 A^M, 3 B&M
  for (genvar i = 0; i < W; i++) begin : g_bit
    always_comb begin
      unique case (sel)
        2'd0:    res[i] = a[i] & b[i];
        2'd1:    res[i] = b[i] | m[i];
        2'd2:    res[i] = a[i] ^ m[i];
        default: res[i] = b[i] & m[i];
      endcase
    end
  end
endmodule

// File: rtl/nib_alu_rot.sv
module nib_alu_rot #(
  parameter int W = 4
) (
  input  logic [W-1:0] val,
  input  logic         cin,
  output logic [W-1:0] res,
  output logic         cout
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    if (i == W - 1) begin : g_top
      assign res[i] = cin;
    end else begin : g_mid
      assign res[i] = val[i+1];
    end
  end

  assign cout = val[0];
endmodule

// File: rtl/nib_alu_flagreg.sv
module nib_alu_flagreg
  import nib_alu_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   en,
  input  flags_t d,
  output flags_t q
);
  flags_t q_nxt;

  always_comb begin
    q_nxt = q;
    if (en) q_nxt = d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_nxt;
  end
endmodule

// File: rtl/nib_alu.sv
module nib_alu
  import nib_alu_pkg::*;
#(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         op_en,
  input  logic [2:0]   op_sel,
  input  logic [W-1:0] opa,
  input  logic [W-1:0] opb,
  input  logic [W-1:0] opm,
  output logic [W-1:0] result,
  output logic [1:0]   dest,
  output logic         flag_z,
  output logic         flag_s,
  output logic         flag_c
);
  localparam int SYNC_STAGES = 2;

  logic [SYNC_STAGES-1:0] rst_pipe;
  logic                   rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[SYNC_STAGES-1];

  alu_op_e                op;
  logic [W-1:0]           ar_res, lg_res, rt_res;
  logic                   ar_cout, rt_cout;
  logic [LOGIC_SEL_W-1:0] lg_sel;
  flags_t                 fq, fd;
  logic                   upd;
  dst_e                   dst;

  assign op = alu_op_e'(op_sel);

  always_comb begin
    unique case (op)
      OP_OR:   lg_sel = 2'd1;
      OP_XOR:  lg_sel = 2'd2;
      OP_TEST: lg_sel = 2'd3;
      default: lg_sel = 2'd0;
    endcase
  end

  nib_alu_arith #(.W(W)) arith_i (
    .a(opa), .b(opb), .sub(op == OP_SUB), .res(ar_res), .cout(ar_cout)
  );

  nib_alu_logic #(.W(W)) logic_i (
    .a(opa), .b(opb), .m(opm), .sel(lg_sel), .res(lg_res)
  );

  nib_alu_rot #(.W(W)) rot_i (
    .val(opb), .cin(fq.c), .res(rt_res), .cout(rt_cout)
  );

  always_comb begin
    result = opa;
    dst    = DST_NONE;
    fd     = fq;
    upd    = 1'b0;
    unique case (op)
      OP_ADD, OP_SUB: begin
        result = ar_res;
        dst    = DST_A;
        fd.z   = (ar_res == '0);
        fd.c   = ar_cout;
        if (op == OP_SUB) fd.s = ar_cout;
        upd    = 1'b1;
      end
      OP_AND, OP_OR, OP_XOR, OP_TEST: begin
        result = lg_res;
        if (op == OP_OR)        dst = DST_B;
        else if (op == OP_TEST) dst = DST_NONE;
        else                    dst = DST_A;
        fd.z   = (lg_res == '0);
        fd.c   = 1'b0;
        upd    = 1'b1;
      end
      OP_RCR: begin
        result = rt_res;
        dst    = DST_B;
        fd.c   = rt_cout;
        upd    = 1'b1;
      end
      default: begin
        result = opa;
      end
    endcase
  end

  nib_alu_flagreg flags_i (
    .clk(clk), .rst_n(rst_sync_n), .en(op_en & upd), .d(fd), .q(fq)
  );

  assign dest   = dst;
  assign flag_z = fq.z;
  assign flag_s = fq.s;
  assign flag_c = fq.c;
endmodule

// File: rtl/nib_alu_chk.sv
module nib_alu_chk #(
  parameter int W = 4
) (
  input logic         clk,
  input logic         rst_n,
  input logic         op_en,
  input logic [2:0]   op_sel,
  input logic [W-1:0] opa,
  input logic [W-1:0] opb,
  input logic [W-1:0] opm,
  input logic [W-1:0] result,
  input logic [1:0]   dest,
  input logic         flag_z,
  input logic         flag_s,
  input logic         flag_c
);
  localparam logic [W:0] MAXV = {1'b0, {W{1'b1}}};

  p_add_carry_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (op_en && op_sel == 3'd1) |=>
      (flag_c == (({1'b0, $past(opa)} + {1'b0, $past(opb)}) > MAXV)));

  p_add_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (op_en && op_sel == 3'd1) |=> (flag_z == ($past(result) == '0)));

  p_sub_sign_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (op_en && op_sel == 3'd2) |=>
      (flag_s == ($past(opa) < $past(opb)) && flag_c == flag_s));

  p_logic_clr_c_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (op_en && op_sel >= 3'd3 && op_sel <= 3'd6) |=> (!flag_c && $stable(flag_s)));

  p_or_mem_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (op_sel == 3'd4) |-> (result == (opb | opm) && dest == 2'd2));

  p_test_nowrite_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (op_sel == 3'd6) |-> (dest == 2'd0));

  p_rcr_msb_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (op_sel == 3'd7) |-> (result[W-1] == flag_c));

  p_rcr_carry_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (op_en && op_sel == 3'd7) |=> (flag_c == $past(opb[0]) && $stable(flag_z)));

  p_nop_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (op_sel == 3'd0) |=> ($stable(flag_z) && $stable(flag_s) && $stable(flag_c)));

  p_en_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!op_en) |=> ($stable(flag_z) && $stable(flag_s) && $stable(flag_c)));
endmodule

bind nib_alu nib_alu_chk #(.W(W)) chk_i (
  .clk(clk), .rst_n(rst_sync_n), .op_en(op_en), .op_sel(op_sel),
  .opa(opa), .opb(opb), .opm(opm), .result(result), .dest(dest),
  .flag_z(flag_z), .flag_s(flag_s), .flag_c(flag_c)
);

// File: tb/nib_alu_tb_top.sv
`timescale 1ns/100ps
module nib_alu_tb_top;
  localparam int W = 4;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         op_en;
  logic [2:0]   op_sel;
  logic [W-1:0] opa, opb, opm;
  logic [W-1:0] result;
  logic [1:0]   dest;
  logic         flag_z, flag_s, flag_c;

  always #2.5 clk = ~clk;

  nib_alu #(.W(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .op_en(op_en), .op_sel(op_sel),
    .opa(opa), .opb(opb), .opm(opm), .result(result), .dest(dest),
    .flag_z(flag_z), .flag_s(flag_s), .flag_c(flag_c)
  );

  typedef struct {
    logic [W-1:0] res;
    logic [1:0]   dst;
    logic         z, s, c;
    string        tag;
  } item_t;

  item_t q[$];
  int    n_run  = 0;
  int    n_fail = 0;
  bit    done   = 0;
  logic  mz, ms, mc;

  task automatic chk_flags(string tag, logic ez, logic es, logic ec);
    n_run++;
    if ({flag_z, flag_s, flag_c} !== {ez, es, ec}) begin
      n_fail++;
      $display("FAIL %s flags zsc=%b%b%b expected %b%b%b", tag,
               flag_z, flag_s, flag_c, ez, es, ec);
    end
  endtask

  // Driver: applies one operation at a falling edge and queues the expectation.
  task automatic do_op(logic en, logic [2:0] op, logic [W-1:0] a,
                       logic [W-1:0] b, logic [W-1:0] m, string tag);
    item_t it;
    logic [W:0] ext;
    @(negedge clk);
    op_en = en; op_sel = op; opa = a; opb = b; opm = m;
    it.tag = tag;
    it.z = mz; it.s = ms; it.c = mc;
    it.res = a; it.dst = 2'd0;
    case (op)
      3'd1: begin ext = {1'b0, a} + {1'b0, b}; it.res = ext[W-1:0]; it.dst = 2'd1;
                  it.z = (it.res == 0); it.c = ext[W]; end
      3'd2: begin it.res = a - b; it.dst = 2'd1; it.z = (it.res == 0);
                  it.s = (a < b); it.c = (a < b); end
      3'd3: begin it.res = a & b; it.dst = 2'd1; it.z = (it.res == 0); it.c = 0; end
      3'd4: begin it.res = b | m; it.dst = 2'd2; it.z = (it.res == 0); it.c = 0; end
      3'd5: begin it.res = a ^ m; it.dst = 2'd1; it.z = (it.res == 0); it.c = 0; end
      3'd6: begin it.res = b & m; it.dst = 2'd0; it.z = (it.res == 0); it.c = 0; end
      3'd7: begin it.res = {mc, b[W-1:1]}; it.dst = 2'd2; it.c = b[0]; end
      default: ;
    endcase
    if (!en) begin it.z = mz; it.s = ms; it.c = mc; end
    mz = it.z; ms = it.s; mc = it.c;
    q.push_back(it);
  endtask

  // Monitor: combinational outputs mid-low-phase, flags after the rising edge.
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (q.size() > 0) begin
        item_t it;
        it = q[0];
        n_run++;
        if (result !== it.res || dest !== it.dst) begin
          n_fail++;
          $display("FAIL %s result=%h dest=%0d expected %h dest=%0d",
                   it.tag, result, dest, it.res, it.dst);
        end
        @(posedge clk);
        #1;
        chk_flags(it.tag, it.z, it.s, it.c);
        void'(q.pop_front());
      end
    end
  end

  task automatic idle(int n);
    @(negedge clk);
    op_en = 0; op_sel = 3'd0;
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0;
    #1;
    chk_flags("R1 during reset", 1'b0, 1'b0, 1'b0);
    repeat (3) @(negedge clk);
    rst_n = 1;
    mz = 0; ms = 0; mc = 0;
    repeat (4) @(negedge clk);
    chk_flags("R1 after release", 1'b0, 1'b0, 1'b0);
  endtask

  initial begin
    #1000000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 0; op_en = 0; op_sel = 0; opa = 0; opb = 0; opm = 0;
    mz = 0; ms = 0; mc = 0;
    repeat (2) @(negedge clk);
    do_reset();

    // R2 and R3: every operand pair
    for (int i = 0; i < 16; i++)
      for (int j = 0; j < 16; j++)
        do_op(1, 3'd1, 4'(i), 4'(j), 4'(i ^ j), "R2 add");
    for (int i = 0; i < 16; i++)
      for (int j = 0; j < 16; j++)
        do_op(1, 3'd2, 4'(i), 4'(j), 4'(j), "R3 sub");

    // R4, R5, R6: logic operations, started with sign set by a borrow
    do_op(1, 3'd2, 4'd0, 4'd1, 4'd0, "R3 borrow");
    for (int i = 0; i < 16; i++)
      for (int j = 0; j < 16; j++)
        do_op(1, 3'd3, 4'(i), 4'(j), 4'(~j), "R4 and");
    for (int i = 0; i < 16; i++)
      for (int j = 0; j < 16; j++)
        do_op(1, 3'd4, 4'(j), 4'(i), 4'(j), "R5 or");
    for (int i = 0; i < 16; i++)
      for (int j = 0; j < 16; j++)
        do_op(1, 3'd5, 4'(i), 4'(~i), 4'(j), "R5 xor");
    do_op(1, 3'd1, 4'd15, 4'd1, 4'd0, "R2 carry set");
    for (int i = 0; i < 16; i++)
      for (int j = 0; j < 16; j++)
        do_op(1, 3'd6, 4'(j), 4'(i), 4'(j), "R6 test");

    // R7: rotate chains through carry
    do_op(1, 3'd1, 4'd15, 4'd1, 4'd0, "R2 carry set");
    for (int i = 0; i < 16; i++)
      do_op(1, 3'd7, 4'd0, 4'(i), 4'd0, "R7 rcr");
    for (int i = 0; i < 8; i++)
      do_op(1, 3'd7, 4'd3, 4'(16 - i), 4'd9, "R7 rcr chain");

    // R8: no-op after flags z=1 s=1 c=1
    do_op(1, 3'd2, 4'd0, 4'd1, 4'd0, "R3 borrow");
    do_op(1, 3'd1, 4'd8, 4'd8, 4'd0, "R2 zero carry");
    for (int i = 0; i < 16; i++)
      do_op(1, 3'd0, 4'(i), 4'(15 - i), 4'(i), "R8 nop");

    // R9: disabled update for every op
    for (int k = 0; k < 8; k++)
      for (int i = 0; i < 4; i++)
        do_op(0, 3'(k), 4'(i * 5), 4'(15 - i), 4'(i + 1), "R9 disabled");

    // R1: reset in mid-run clears non-zero flags
    do_op(1, 3'd2, 4'd2, 4'd3, 4'd0, "R3 set s/c");
    idle(3);
    do_reset();
    do_op(1, 3'd1, 4'd7, 4'd9, 4'd0, "R2 after reset");
    idle(3);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule